// File: doc/BRIEF.md
# Readout event fragment framer

The framer turns one readout event into a framed stream of 32-bit words on a valid/ready output. A frame starts with a begin control word and a nine-word header. The header holds fixed identity words, run and source fields taken from configuration inputs, and an event word that combines a reset counter with an event number. A counted user header of one to four words follows. Then come the payload words, forwarded from an upstream valid/ready stream up to the word marked last. A trailer ends the frame: two status words, the status count, the number of payload words that actually went through, a status-position word, and a closing control word.

The block also keeps the event identity. A trigger-accept pulse advances a 24-bit event number. An event-counter-reset pulse clears that number and advances an 8-bit reset counter. The identity is captured when a frame starts, so pulses that arrive during a frame only affect the next one. A frame is requested by holding `frame_req` high. The configuration inputs are expected to stay stable while a frame is in flight. The output is a single register stage, so a low `out_ready` holds the current word without losing anything.

Top module: `evt_frag_framer`

## Requirements
- R1: Each frame starts with control word 0xB0F00000 and ends with control word 0xE0F00000.
- R2: After the begin word, the first four header words are: marker 0xEE1234EE, header size 9, version 0x03000000 (major 0x0300 in bits 31:16, minor 0 in bits 15:0), and the source word {8'h00, sub_det_id in 23:16, module_id in 15:0}.
- R3: The remaining header words are, in order: the run word {run_type in 31:24, run_num in 23:0}, the event word (R4), the bunch word with bunch_id in bits 11:0, the trigger word with trig_type in bits 7:0, and det_evt_type. All unused bits are zero.
- R4: The event word is {reset counter in 31:24, event number in 23:0}, captured at frame start. Each trig_accept pulse adds one to the event number. A pulse during a frame changes only later frames.
- R5: An ecr_pulse clears the event number and adds one to the reset counter, which wraps modulo 256. When ecr_pulse and trig_accept are high in the same cycle, the reset wins and the trigger has no effect.
- R6: The user header length n is uh_words_cfg clamped to 1..4 (0 gives 1, 5 to 7 give 4). Its first word is {uh_tag in 31:4, n in 3:0}. User header word k (k = 1..n-1) is uh_ext[32k-1:32k-32].
- R7: Payload words are forwarded unchanged and in order, ending with the word that has pl_last high. Every frame carries at least one payload word. pl_ready is high only while the output register can take a word.
- R8: The trailer is status0, status1, the value 2, the count of payload words in this frame, and the value 1.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change. No word is dropped or repeated.
- R10: After reset, out_valid and pl_ready are 0, and both the event number and the reset counter are 0.
- R11: A frame starts only when frame_req is high and the previous end word has been accepted. Frames can follow back to back. With frame_req low, nothing is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_accept | input | 1 | Trigger-accept pulse, advances the event number |
| ecr_pulse | input | 1 | Event-counter-reset pulse |
| frame_req | input | 1 | Request to build a frame |
| sub_det_id | input | 8 | Sub-detector identifier for the source word |
| module_id | input | 16 | Module identifier for the source word |
| run_type | input | 8 | Run type |
| run_num | input | 24 | Run number |
| bunch_id | input | 12 | Bunch crossing number |
| trig_type | input | 8 | Trigger type |
| det_evt_type | input | 32 | Detector-specific event type |
| uh_words_cfg | input | 3 | Requested user header word count |
| uh_tag | input | 28 | Upper bits of the first user header word |
| uh_ext | input | 96 | Extra user header words, word 1 in the low bits |
| status0 | input | 32 | First status word |
| status1 | input | 32 | Second status word |
| pl_valid | input | 1 | Payload word valid |
| pl_data | input | 32 | Payload word |
| pl_last | input | 1 | Marks the last payload word |
| pl_ready | output | 1 | Payload word accepted |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| out_ready | input | 1 | Downstream ready |

## Verification
The bench goes after these cases:
- Out-of-range user header counts. A design without the clamp would emit zero or more than four user words and shift every later word.
- A trigger pulse that lands in the middle of a frame. A framer that reads the live counter instead of a snapshot would show the new number in the current frame.
- A reset pulse in the same cycle as a trigger, and 256 back-to-back resets. These catch a wrong priority or a reset counter that saturates instead of wrapping.
- Long low-ready stretches and gappy payload valid. A wrong stall path would drop or duplicate a word, or miscount the payload, and the word-by-word compare and the data count in the trailer both expose that.

// File: rtl/frag_pkg.sv
package frag_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_UH, ST_PAY, ST_TRL, ST_EOF
  } fstate_t;

  localparam logic [31:0] BOF_WORD = 32'hB0F0_0000;
  localparam logic [31:0] EOF_WORD = 32'hE0F0_0000;
  localparam logic [31:0] MARKER   = 32'hEE12_34EE;
  localparam logic [31:0] HDR_SIZE = 32'd9;
  localparam logic [31:0] FMT_VER  = 32'h0300_0000;
  localparam logic [31:0] STAT_CNT = 32'd2;
  localparam logic [31:0] STAT_POS = 32'd1;

  localparam int IDX_W    = 4;
  localparam int HDR_LAST = 9;
  localparam int TRL_LAST = 4;
endpackage

// File: rtl/frag_evid.sv
module frag_evid #(
  parameter int EVW = 24,
  parameter int RCW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           trig,
  input  logic           ecr,
  output logic [EVW-1:0] ev_num,
  output logic [RCW-1:0] rc_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_num <= '0;
      rc_cnt <= '0;
    end else if (ecr) begin
      ev_num <= '0;
      rc_cnt <= rc_cnt + RCW'(1);
    end else if (trig) begin
      ev_num <= ev_num + EVW'(1);
    end
  end
endmodule

// File: rtl/frag_out_reg.sv
module frag_out_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] dout,
  output logic          free
);
  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/frag_word_sel.sv
module frag_word_sel
  import frag_pkg::*;
#(
  parameter int EVW    = 24,
  parameter int RCW    = 8,
  parameter int BCW    = 12,
  parameter int TTW    = 8,
  parameter int DCW    = 16,
  parameter int UH_MAX = 4,
  localparam int UH_CW = $clog2(UH_MAX + 1),
  localparam int UH_IW = (UH_MAX > 1) ? $clog2(UH_MAX) : 1
) (
  input  fstate_t                 state,
  input  logic [IDX_W-1:0]        idx,
  input  logic [7:0]              sub_det_id,
  input  logic [15:0]             module_id,
  input  logic [7:0]              run_type,
  input  logic [23:0]             run_num,
  input  logic [EVW-1:0]          ev_snap,
  input  logic [RCW-1:0]          rc_snap,
  input  logic [BCW-1:0]          bunch_id,
  input  logic [TTW-1:0]          trig_type,
  input  logic [31:0]             det_evt_type,
  input  logic [UH_CW-1:0]        uh_n,
  input  logic [27:0]             uh_tag,
  input  logic [(UH_MAX-1)*32-1:0] uh_ext,
  input  logic [31:0]             pl_data,
  input  logic [31:0]             status0,
  input  logic [31:0]             status1,
  input  logic [DCW-1:0]          dcount,
  output logic [31:0]             word
);
  logic [31:0] uh_arr [UH_MAX];

  assign uh_arr[0] = {uh_tag, 4'(uh_n)};
  for (genvar k = 1; k < UH_MAX; k++) begin : g_uh
    assign uh_arr[k] = uh_ext[(k-1)*32 +: 32];
  end

  always_comb begin
    word = EOF_WORD;
    case (state)
      ST_IDLE: word = BOF_WORD;
      ST_HDR: begin
        case (idx)
          4'd1:    word = MARKER;
          4'd2:    word = HDR_SIZE;
          4'd3:    word = FMT_VER;
          4'd4:    word = {8'h00, sub_det_id, module_id};
          4'd5:    word = {run_type, run_num};
          4'd6:    word = 32'({rc_snap, ev_snap});
          4'd7:    word = 32'(bunch_id);
          4'd8:    word = 32'(trig_type);
          default: word = det_evt_type;
        endcase
      end
      ST_UH:  word = uh_arr[idx[UH_IW-1:0]];
      ST_PAY: word = pl_data;
      ST_TRL: begin
        case (idx)
          4'd0:    word = status0;
          4'd1:    word = status1;
          4'd2:    word = STAT_CNT;
          4'd3:    word = 32'(dcount);
          default: word = STAT_POS;
        endcase
      end
      default: word = EOF_WORD;
    endcase
  end
endmodule

// File: rtl/evt_frag_framer.sv
module evt_frag_framer
  import frag_pkg::*;
#(
  parameter int EVW    = 24,
  parameter int RCW    = 8,
  parameter int BCW    = 12,
  parameter int TTW    = 8,
  parameter int DCW    = 16,
  parameter int UH_MAX = 4,
  localparam int UH_CW = $clog2(UH_MAX + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     trig_accept,
  input  logic                     ecr_pulse,
  input  logic                     frame_req,
  input  logic [7:0]               sub_det_id,
  input  logic [15:0]              module_id,
  input  logic [7:0]               run_type,
  input  logic [23:0]              run_num,
  input  logic [BCW-1:0]           bunch_id,
  input  logic [TTW-1:0]           trig_type,
  input  logic [31:0]              det_evt_type,
  input  logic [2:0]               uh_words_cfg,
  input  logic [27:0]              uh_tag,
  input  logic [(UH_MAX-1)*32-1:0] uh_ext,
  input  logic [31:0]              status0,
  input  logic [31:0]              status1,
  input  logic                     pl_valid,
  input  logic [31:0]              pl_data,
  input  logic                     pl_last,
  output logic                     pl_ready,
  output logic                     out_valid,
  output logic [31:0]              out_data,
  input  logic                     out_ready
);
  fstate_t          state;
  logic [IDX_W-1:0] idx;
  logic [EVW-1:0]   ev_num, ev_snap;
  logic [RCW-1:0]   rc_cnt, rc_snap;
  logic [UH_CW-1:0] uh_n, uh_req;
  logic [DCW-1:0]   dcount;
  logic [31:0]      word;
  logic             free, have_word, load;

  frag_evid #(.EVW(EVW), .RCW(RCW)) u_evid (
    .clk(clk), .rst(rst), .trig(trig_accept), .ecr(ecr_pulse),
    .ev_num(ev_num), .rc_cnt(rc_cnt)
  );

  always_comb begin
    if (uh_words_cfg == 3'd0)
      uh_req = UH_CW'(1);
    else if (32'(uh_words_cfg) > UH_MAX)
      uh_req = UH_CW'(UH_MAX);
    else
      uh_req = UH_CW'(uh_words_cfg);
  end

  always_comb begin
    case (state)
      ST_IDLE: have_word = frame_req;
      ST_PAY:  have_word = pl_valid;
      default: have_word = 1'b1;
    endcase
  end

  assign load     = free && have_word;
  assign pl_ready = (state == ST_PAY) && free;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx     <= '0;
      ev_snap <= '0;
      rc_snap <= '0;
      uh_n    <= UH_CW'(1);
      dcount  <= '0;
    end else if (load) begin
      case (state)
        ST_IDLE: begin
          state   <= ST_HDR;
          idx     <= IDX_W'(1);
          ev_snap <= ev_num;
          rc_snap <= rc_cnt;
          uh_n    <= uh_req;
          dcount  <= '0;
        end
        ST_HDR: begin
          if (idx == IDX_W'(HDR_LAST)) begin
            state <= ST_UH;
            idx   <= '0;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        ST_UH: begin
          if (idx == IDX_W'(uh_n) - IDX_W'(1)) begin
            state <= ST_PAY;
            idx   <= '0;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        ST_PAY: begin
          dcount <= dcount + DCW'(1);
          if (pl_last) begin
            state <= ST_TRL;
            idx   <= '0;
          end
        end
        ST_TRL: begin
          if (idx == IDX_W'(TRL_LAST)) state <= ST_EOF;
          else idx <= idx + IDX_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  frag_word_sel #(
    .EVW(EVW), .RCW(RCW), .BCW(BCW), .TTW(TTW), .DCW(DCW), .UH_MAX(UH_MAX)
  ) u_sel (
    .state(state), .idx(idx), .sub_det_id(sub_det_id), .module_id(module_id),
    .run_type(run_type), .run_num(run_num), .ev_snap(ev_snap), .rc_snap(rc_snap),
    .bunch_id(bunch_id), .trig_type(trig_type), .det_evt_type(det_evt_type),
    .uh_n(uh_n), .uh_tag(uh_tag), .uh_ext(uh_ext), .pl_data(pl_data),
    .status0(status0), .status1(status1), .dcount(dcount), .word(word)
  );

  frag_out_reg #(.DW(32)) u_oreg (
    .clk(clk), .rst(rst), .load(load), .din(word), .ready(out_ready),
    .valid(out_valid), .dout(out_data), .free(free)
  );
endmodule

// File: rtl/frag_framer_chk.sv
module frag_framer_chk #(
  parameter int EVW = 24,
  parameter int RCW = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           trig_accept,
  input logic           ecr_pulse,
  input logic           out_valid,
  input logic           out_ready,
  input logic [31:0]    out_data,
  input logic           pl_ready,
  input logic [EVW-1:0] ev_num,
  input logic [RCW-1:0] rc_cnt
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R9: a stalled word is held unchanged
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R7: payload taken only when the output stage can take it
  assert_pl_ready_R7: assert property (@(posedge clk) disable iff (rst)
    pl_ready |-> (!out_valid || out_ready));

  // R5: counter reset clears event number and advances the reset counter
  assert_ecr_R5: assert property (@(posedge clk) disable iff (rst)
    ecr_pulse |=> (ev_num == '0) && (rc_cnt == $past(rc_cnt) + RCW'(1)));

  // R4: trigger advances the event number
  assert_trig_R4: assert property (@(posedge clk) disable iff (rst)
    trig_accept && !ecr_pulse |=> ev_num == $past(ev_num) + EVW'(1));

  // R4: no pulse, no change
  assert_idhold_R4: assert property (@(posedge clk) disable iff (rst)
    !trig_accept && !ecr_pulse |=> $stable(ev_num) && $stable(rc_cnt));

  // R10: quiet right after reset
  assert_reset_R10: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> !out_valid && !pl_ready && ev_num == '0 && rc_cnt == '0);
endmodule

bind evt_frag_framer frag_framer_chk #(.EVW(EVW), .RCW(RCW)) u_chk (
  .clk(clk), .rst(rst), .trig_accept(trig_accept), .ecr_pulse(ecr_pulse),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .pl_ready(pl_ready), .ev_num(ev_num), .rc_cnt(rc_cnt)
);

// File: tb/evt_frag_framer_bench.sv
module evt_frag_framer_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, trig_accept, ecr_pulse, frame_req;
  logic [7:0]  sub_det_id, run_type, trig_type;
  logic [15:0] module_id;
  logic [23:0] run_num;
  logic [11:0] bunch_id;
  logic [31:0] det_evt_type, status0, status1, pl_data, out_data;
  logic [2:0]  uh_words_cfg;
  logic [27:0] uh_tag;
  logic [95:0] uh_ext;
  logic        pl_valid, pl_last, pl_ready, out_valid, out_ready;

  evt_frag_framer u_evt_frag_framer (.*);

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [23:0] m_ev = '0;
  logic [7:0]  m_rc = '0;
  logic [31:0] pay [64];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int uh_clamp(int c);
    if (c == 0) return 1;
    if (c > 4) return 4;
    return c;
  endfunction

  task automatic push(logic [31:0] w, string t);
    exp_q.push_back(w);
    tag_q.push_back(t);
  endtask

  task automatic rand_cfg();
    sub_det_id = 8'($urandom); module_id = 16'($urandom);
    run_type = 8'($urandom); run_num = 24'($urandom);
    bunch_id = 12'($urandom); trig_type = 8'($urandom);
    det_evt_type = $urandom; uh_tag = 28'($urandom);
    uh_ext = {$urandom, $urandom, $urandom};
    status0 = $urandom; status1 = $urandom;
  endtask

  task automatic pulse(bit t, bit e);
    @(negedge clk);
    trig_accept = t; ecr_pulse = e;
    if (e) begin m_ev = '0; m_rc = m_rc + 8'd1; end
    else if (t) m_ev = m_ev + 24'd1;
    @(negedge clk);
    trig_accept = 1'b0; ecr_pulse = 1'b0;
  endtask

  // expected frame built from R1..R8
  task automatic build(int plen);
    int n = uh_clamp(int'(uh_words_cfg));
    push(32'hB0F00000, "R1");
    push(32'hEE1234EE, "R2"); push(32'd9, "R2"); push(32'h03000000, "R2");
    push({8'h00, sub_det_id, module_id}, "R2");
    push({run_type, run_num}, "R3");
    push({m_rc, m_ev}, "R4");
    push({20'h0, bunch_id}, "R3"); push({24'h0, trig_type}, "R3");
    push(det_evt_type, "R3");
    push({uh_tag, 4'(n)}, "R6");
    for (int k = 1; k < n; k++) push(uh_ext[32*(k-1) +: 32], "R6");
    for (int k = 0; k < plen; k++) push(pay[k], "R7");
    push(status0, "R8"); push(status1, "R8"); push(32'd2, "R8");
    push(32'(plen), "R8"); push(32'd1, "R8");
    push(32'hE0F00000, "R1");
  endtask

  task automatic run_frame(int plen, int uh, int rdy_pct, int val_pct, int mid_trig);
    int  pidx = 0, cyc = 0;
    bit  started = 0, pfire = 0;
    uh_words_cfg = 3'(uh);
    for (int k = 0; k < plen; k++) pay[k] = $urandom;
    build(plen);
    while (exp_q.size() > 0 && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (pfire) begin pidx++; pl_valid = 1'b0; end
      trig_accept = started && (cyc == mid_trig);
      if (trig_accept) m_ev = m_ev + 24'd1;
      out_ready = ($urandom % 100) < rdy_pct;
      if (pidx < plen) begin
        if (!pl_valid) pl_valid = ($urandom % 100) < val_pct;
        pl_data = pay[pidx];
        pl_last = (pidx == plen - 1);
      end else begin
        pl_valid = 1'b0; pl_last = 1'b0;
      end
      frame_req = !started;
      #1;
      if (frame_req && out_valid) started = 1;
      if (out_valid && out_ready) begin
        logic [31:0] e = exp_q.pop_front();
        string t = tag_q.pop_front();
        chk(out_data == e, t, out_data, e);
      end
      pfire = pl_valid && pl_ready;
    end
    if (exp_q.size() > 0) begin
      chk(1'b0, "R9 frame incomplete", 32'(exp_q.size()), 32'd0);
      exp_q.delete(); tag_q.delete();
    end
    frame_req = 1'b0; pl_valid = 1'b0; trig_accept = 1'b0;
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    rst = 1; trig_accept = 0; ecr_pulse = 0; frame_req = 0;
    pl_valid = 0; pl_data = 0; pl_last = 0; out_ready = 0; uh_words_cfg = 1;
    rand_cfg();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: quiet after reset
    chk(out_valid == 1'b0, "R10 out_valid", 32'(out_valid), 0);
    chk(pl_ready == 1'b0, "R10 pl_ready", 32'(pl_ready), 0);
    // R10/R4: first frame carries event word 0
    run_frame(1, 1, 100, 100, -1);
    // R11: no frame without a request
    repeat (6) @(negedge clk);
    out_ready = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R11 idle", 32'(out_valid), 0);
    end
    // R6 clamp corners
    pulse(1, 0);
    run_frame(3, 0, 100, 100, -1);
    run_frame(2, 7, 100, 100, -1);
    run_frame(4, 4, 80, 80, -1);
    // R5 ecr and trigger together: reset wins
    pulse(1, 1);
    run_frame(2, 2, 100, 100, -1);
    // R4 trigger during a frame shows in the next one only
    run_frame(6, 3, 90, 90, 4);
    run_frame(1, 1, 100, 100, -1);
    // R5 wrap of the reset counter after 256 resets
    @(negedge clk);
    ecr_pulse = 1'b1;
    repeat (256) @(negedge clk);
    ecr_pulse = 1'b0;
    m_ev = '0;
    pulse(1, 0);
    run_frame(2, 1, 100, 100, -1);
    // R9 heavy stall
    run_frame(10, 4, 10, 50, -1);
    // random mix
    for (int i = 0; i < 40; i++) begin
      rand_cfg();
      repeat ($urandom % 3) pulse(1, 0);
      if (($urandom % 5) == 0) pulse(0, 1);
      run_frame(1 + int'($urandom % 20), int'($urandom % 8),
                30 + int'($urandom % 71), 30 + int'($urandom % 71),
                (($urandom % 2) == 0) ? 3 + int'($urandom % 6) : -1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule